// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a serial slave that reads and writes a small bank of 8-bit configuration registers. It uses three signals: an active-low chip select, a serial clock and one data line that can carry data in both directions. The data line is presented as separate input, output and output-enable signals so that a pad outside the block can drive it. The serial signals are sampled with the block's own clock `clk`. They are taken to be already synchronous to it, and the serial clock must stay at least three `clk` cycles in each level.

A frame opens with a 16-bit instruction. The instruction holds a read flag, a two-bit length code and a 13-bit register address. Data bytes follow. The length code selects one, two or three bytes, or an open-ended stream that ends only when chip select is released. The address moves by one after every data byte, and a configuration bit selects the bit order of the whole frame. In a fixed-length frame, chip select may be lifted between bytes and the frame resumes afterwards. Releasing chip select in the middle of a byte abandons the frame.

Top module: `spi3w_reg_port`

## Requirements
- R1: After reset every register reads 0, the port is in MSB-first order, it waits for an instruction, and `sdio_oe` is low.
- R2: The instruction is 16 bits: bit 15 is the read flag (1 = read), bits 14:13 are the length code and bits 12:0 are the address. The port samples `sdio_in` on each rising edge of `sclk`. In MSB-first order bit 15 is sent first. In LSB-first order bit 0 is sent first, and each data byte is also sent least significant bit first.
- R3: Length codes 00, 01 and 10 transfer 1, 2 and 3 data bytes. After the last byte the very next bit starts a new instruction, even while `csb` stays low.
- R4: Length code 11 streams data bytes for as long as `csb` stays low. Raising `csb` at a byte boundary ends the stream.
- R5: After each data byte the address steps by one modulo 2^13. It steps down in MSB-first order and up in LSB-first order, using the order in force during that byte.
- R6: While `csb` is high, `sclk` and `sdio_in` have no effect.
- R7: In a fixed-length frame, raising `csb` at a byte boundary and then lowering it again resumes the frame with the next data byte.
- R8: Raising `csb` after a partial instruction or a partial data byte discards it. No register is written, and the next bit begins a new instruction.
- R9: In a read frame `sdio_oe` goes high after the instruction, before the first data bit is sampled. The output bit changes after each falling `sclk` edge. `sdio_oe` stays low during the instruction and during write frames.
- R10: `sdio_oe` drops in the same cycle that `csb` rises.
- R11: Register 0 is the configuration register. Its bit 0 selects LSB-first order when it is 1, and its other bits read as 0. Registers 1 to NREGS-1 are fully readable and writable.
- R12: Addresses at or above NREGS read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| csb | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdio_in | input | 1 | Serial data arriving from the pad |
| sdio_out | output | 1 | Serial read data toward the pad |
| sdio_oe | output | 1 | Pad output enable for read data |

## Verification
Any fault in the bit counter, the phase or the length bookkeeping shows up at the ports within one frame. Readback bytes come out shifted or taken from a wrong address, or the next instruction is misparsed, which corrupts later reads. A wrong output-enable state appears at the very next bit sample or at the next chip-select release. A stale bit order or a wrong address direction corrupts the second byte of any multi-byte frame. The random frames are mixed with directed frames for stalls, aborts, streams, order switching and unmapped addresses.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

    localparam int INSTR_BITS = 16;
    localparam int ADDR_W     = 13;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 4;

    typedef enum logic [0:0] {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        LEN_ONE    = 2'b00,
        LEN_TWO    = 2'b01,
        LEN_THREE  = 2'b10,
        LEN_STREAM = 2'b11
    } len_e;

    typedef struct packed {
        logic              rd;
        len_e              len;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    function automatic logic [INSTR_BITS-1:0] shift_word(
        input logic [INSTR_BITS-1:0] cur, input logic b, input logic lsb);
        return lsb ? {b, cur[INSTR_BITS-1:1]} : {cur[INSTR_BITS-2:0], b};
    endfunction

    function automatic logic [BYTE_W-1:0] shift_byte(
        input logic [BYTE_W-1:0] cur, input logic b, input logic lsb);
        return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic [2:0] bit_pos(input logic [2:0] k, input logic lsb);
        return lsb ? k : 3'd7 - k;
    endfunction

    function automatic logic [ADDR_W-1:0] next_addr(
        input logic [ADDR_W-1:0] a, input logic lsb);
        return lsb ? a + 1'b1 : a - 1'b1;
    endfunction

endpackage

// File: rtl/spi3w_edge.sv
module spi3w_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/spi3w_regbank.sv
module spi3w_regbank
    import spi3w_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              lsb_first
);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam logic [ADDR_W-1:0] NREGS_A = ADDR_W'(NREGS);

    logic [NREGS-1:0][BYTE_W-1:0] regs_q;
    logic                         mapped;
    logic [IDX_W-1:0]             idx;

    assign mapped = acc_addr < NREGS_A;
    assign idx    = acc_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en && mapped) begin
            for (int i = 0; i < NREGS; i++) begin
                if (idx == IDX_W'(i)) begin
                    if (i == 0) regs_q[i] <= {{(BYTE_W-1){1'b0}}, wr_data[0]};
                    else        regs_q[i] <= wr_data;
                end
            end
        end
    end

    assign rd_data   = mapped ? regs_q[idx] : '0;
    assign lsb_first = regs_q[0][0];

    assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped) |=> $stable(regs_q));

    assert_cfg_reset_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lsb_first);
endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
    import spi3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csb,
    input  logic              sdi,
    input  logic              rise,
    input  logic              fall,
    input  logic              lsb_first,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              oe
);
    phase_e                phase_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [INSTR_BITS-1:0] sh_q;
    logic                  rd_q;
    len_e                  len_q;
    logic [1:0]            left_q;
    logic [ADDR_W-1:0]     addr_q;
    logic                  sdo_q;
    logic                  oe_q;

    logic [INSTR_BITS-1:0] word_nxt;
    logic [BYTE_W-1:0]     byte_nxt;
    instr_t                instr;
    logic                  byte_end;
    logic                  last_byte;

    assign word_nxt  = shift_word(sh_q, sdi, lsb_first);
    assign byte_nxt  = shift_byte(sh_q[BYTE_W-1:0], sdi, lsb_first);
    assign instr     = instr_t'(word_nxt);
    assign byte_end  = rise && !csb && phase_q == PH_DATA && cnt_q == CNT_W'(BYTE_W-1);
    assign last_byte = len_q != LEN_STREAM && left_q == 2'd0;

    assign wr_en    = byte_end && !rd_q;
    assign wr_data  = byte_nxt;
    assign acc_addr = addr_q;
    assign sdo      = sdo_q;
    assign oe       = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INSTR;
            cnt_q   <= '0;
            sh_q    <= '0;
            rd_q    <= 1'b0;
            len_q   <= LEN_ONE;
            left_q  <= '0;
            addr_q  <= '0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else if (csb) begin
            oe_q <= 1'b0;
            if (cnt_q != '0 || (phase_q == PH_DATA && len_q == LEN_STREAM)) begin
                phase_q <= PH_INSTR;
                cnt_q   <= '0;
            end
        end else if (rise) begin
            if (phase_q == PH_INSTR) begin
                sh_q <= word_nxt;
                if (cnt_q == CNT_W'(INSTR_BITS-1)) begin
                    phase_q <= PH_DATA;
                    cnt_q   <= '0;
                    rd_q    <= instr.rd;
                    len_q   <= instr.len;
                    left_q  <= instr.len;
                    addr_q  <= instr.addr;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                sh_q <= {{(INSTR_BITS-BYTE_W){1'b0}}, byte_nxt};
                if (byte_end) begin
                    cnt_q  <= '0;
                    addr_q <= next_addr(addr_q, lsb_first);
                    if (last_byte) begin
                        phase_q <= PH_INSTR;
                        oe_q    <= 1'b0;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else if (phase_q == PH_DATA && rd_q && (fall || !oe_q)) begin
            sdo_q <= rd_data[bit_pos(cnt_q[2:0], lsb_first)];
            oe_q  <= 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_q == PH_INSTR && cnt_q == '0 && !oe_q));

    assert_csb_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        csb |=> ($stable(addr_q) && $stable(sh_q) && $stable(rd_q)));

    assert_midbyte_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (csb && cnt_q != '0) |=> (phase_q == PH_INSTR && cnt_q == '0));

    assert_oe_read_only_R9: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (rd_q && phase_q == PH_DATA));

    assert_oe_release_R10: assert property (@(posedge clk) disable iff (rst)
        csb |=> !oe_q);

    assert_data_count_R3: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_DATA |-> cnt_q < CNT_W'(BYTE_W));

    assert_no_write_on_read_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !oe_q);
endmodule

// File: rtl/spi3w_reg_port.sv
module spi3w_reg_port
    import spi3w_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic csb,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe
);
    logic              rise;
    logic              fall;
    logic              lsb_first;
    logic              wr_en;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              oe_int;

    spi3w_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    spi3w_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .csb       (csb),
        .sdi       (sdio_in),
        .rise      (rise),
        .fall      (fall),
        .lsb_first (lsb_first),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .sdo       (sdio_out),
        .oe        (oe_int)
    );

    spi3w_regbank #(.NREGS(NREGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .lsb_first (lsb_first)
    );

    assign sdio_oe = oe_int & ~csb;
endmodule

// File: tb/spi3w_reg_port_bench.sv
module spi3w_reg_port_bench;
    localparam int H = 4;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csb = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out;
    logic sdio_oe;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0]  m_regs [0:NR-1];
    logic        m_lsb;
    logic [7:0]  wbuf [0:7];

    always #2 clk = ~clk;

    spi3w_reg_port #(.NREGS(NR)) u_spi3w_reg_port (
        .clk      (clk),
        .rst      (rst),
        .csb      (csb),
        .sclk     (sclk),
        .sdio_in  (sdio_in),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ref_read(input logic [12:0] a);
        if (a >= 13'(NR)) return 8'h00;
        if (a == 13'd0)   return {7'b0, m_lsb};
        return m_regs[a[2:0]];
    endfunction

    function automatic logic [12:0] ref_step(input logic [12:0] a, input logic lsb);
        return lsb ? a + 13'd1 : a - 13'd1;
    endfunction

    task automatic clk_bit(input logic b, output logic so, output logic oe);
        wait_cyc(H);
        so = sdio_out;
        oe = sdio_oe;
        sdio_in = b;
        sclk = 1'b1;
        wait_cyc(H);
        sclk = 1'b0;
    endtask

    task automatic send_instr(input bit rd, input logic [1:0] code, input logic [12:0] addr,
                              input int nbits);
        logic [15:0] w;
        logic so, oe;
        w = {rd, code, addr};
        for (int i = 0; i < nbits; i++) begin
            clk_bit(w[m_lsb ? i : 15 - i], so, oe);
            chk(oe == 1'b0, "R9 oe during instruction", oe, 0);
        end
    endtask

    task automatic run_frame(input bit rd, input logic [1:0] code, input logic [12:0] addr,
                             input int nbytes, input bit stall, input bit hold_low,
                             input string tag);
        logic [12:0] a;
        logic [7:0]  got, exp;
        logic        ord, so, oe, oe_ok;
        int          bi;
        csb = 1'b0;
        send_instr(rd, code, addr, 16);
        a = addr;
        for (int k = 0; k < nbytes; k++) begin
            ord = m_lsb;
            exp = ref_read(a);
            got = 8'h00;
            oe_ok = 1'b1;
            for (int j = 0; j < 8; j++) begin
                bi = ord ? j : 7 - j;
                clk_bit(rd ? 1'b0 : wbuf[k][bi], so, oe);
                if (rd) got[bi] = so;
                if (oe != rd) oe_ok = 1'b0;
            end
            if (rd) chk(got == exp, tag, got, exp);
            chk(oe_ok, "R9 oe level during data", oe_ok, 1);
            if (!rd && a < 13'(NR)) begin
                if (a == 13'd0) m_lsb = wbuf[k][0];
                else            m_regs[a[2:0]] = wbuf[k];
            end
            a = ref_step(a, ord);
            if (stall && k < nbytes - 1) begin
                wait_cyc(H);
                csb = 1'b1;
                wait_cyc(10);
                csb = 1'b0;
            end
        end
        if (!hold_low) begin
            wait_cyc(H);
            csb = 1'b1;
            wait_cyc(2);
            chk(sdio_oe == 1'b0, "R10 oe after csb release", sdio_oe, 0);
            wait_cyc(H);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_run();
    end

    initial begin
        logic so, oe;
        logic [1:0] code;
        int nb;
        bit rd, st;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) m_regs[i] = 8'h00;
        m_lsb = 1'b0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);

        chk(sdio_oe == 1'b0, "R1 oe after reset", sdio_oe, 0);
        run_frame(1, 2'b10, 13'd3, 3, 0, 0, "R1 registers zero after reset");
        run_frame(1, 2'b00, 13'd0, 1, 0, 0, "R1 config after reset");

        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        run_frame(0, 2'b10, 13'd5, 3, 0, 0, "R3");
        run_frame(1, 2'b10, 13'd5, 3, 0, 0, "R5 downward MSB-first");
        run_frame(1, 2'b00, 13'd4, 1, 0, 0, "R2 single byte read");

        wbuf[0] = 8'h5E; wbuf[1] = 8'hC7;
        run_frame(0, 2'b01, 13'd2, 2, 1, 0, "R7");
        run_frame(1, 2'b01, 13'd2, 2, 1, 0, "R7 stalled read");

        csb = 1'b0;
        send_instr(0, 2'b00, 13'd6, 16);
        for (int j = 0; j < 3; j++) clk_bit(1'b1, so, oe);
        csb = 1'b1;
        wait_cyc(6);
        run_frame(1, 2'b00, 13'd6, 1, 0, 0, "R8 partial data byte discarded");
        csb = 1'b0;
        send_instr(1, 2'b00, 13'd5, 5);
        csb = 1'b1;
        wait_cyc(6);
        run_frame(1, 2'b00, 13'd5, 1, 0, 0, "R8 partial instruction discarded");

        for (int j = 0; j < 20; j++) begin
            sdio_in = 1'($urandom);
            sclk = ~sclk;
            wait_cyc(H);
        end
        sclk = 1'b0;
        wait_cyc(H);
        run_frame(1, 2'b10, 13'd5, 3, 0, 0, "R6 inputs ignored while deselected");

        wbuf[0] = 8'hEE;
        run_frame(0, 2'b00, 13'd9, 1, 0, 0, "R12");
        run_frame(1, 2'b01, 13'd9, 2, 0, 0, "R12 unmapped reads zero");

        wbuf[0] = 8'h66;
        run_frame(0, 2'b00, 13'd1, 1, 0, 1, "R3");
        run_frame(1, 2'b00, 13'd1, 1, 0, 1, "R3 back-to-back with csb low");
        run_frame(1, 2'b00, 13'd7, 1, 0, 0, "R3 second frame");

        for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'h11 * (k + 1));
        run_frame(0, 2'b11, 13'd7, 5, 0, 0, "R4");
        run_frame(1, 2'b11, 13'd7, 5, 0, 0, "R4 stream readback");

        wbuf[0] = 8'hFF;
        run_frame(0, 2'b00, 13'd0, 1, 0, 0, "R11");
        run_frame(1, 2'b00, 13'd0, 1, 0, 0, "R11 config reads only bit 0");
        wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
        run_frame(0, 2'b10, 13'd1, 3, 0, 0, "R5");
        run_frame(1, 2'b10, 13'd1, 3, 0, 0, "R5 upward LSB-first");
        run_frame(1, 2'b11, 13'd8190, 4, 0, 0, "R5 wrap in LSB-first");
        wbuf[0] = 8'h00;
        run_frame(0, 2'b00, 13'd0, 1, 0, 0, "R11");
        run_frame(1, 2'b00, 13'd1, 1, 0, 0, "R2 back to MSB-first");

        for (int f = 0; f < 40; f++) begin
            rd = 1'($urandom);
            code = 2'($urandom);
            nb = (code == 2'b11) ? 1 + int'($urandom % 4) : int'(code) + 1;
            st = (code != 2'b11) && 1'($urandom);
            for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
            run_frame(rd, code, 13'($urandom % 12), nb, st, 0, "R2 random frame");
        end
        for (int a = 1; a < NR; a++)
            run_frame(1, 2'b00, 13'(a), 1, 0, 0, "R11 final register contents");

        finish_run();
    end
endmodule